// File: doc/BRIEF.md
# Programmable Source Supervisory Sequencer

This block is the state machine that brings a programmable voltage/current source from power-up to closed-loop output. After start it configures the voltage converter and then the current converter. It sets the voltage range relay, the current range relay and the output relay to their defaults. It then runs the self-check and calibration, latches the setpoints and the operating mode, applies the requested range selects, enables the measurement converters and finally closes the output relay with the regulation loop enabled.

While the loop runs, the block compares the compliance reading (the measurement from the slave converter) with its latched limit. When the limit is exceeded it switches between voltage-source and current-source operation. On every switch it swaps which converter acts as master and which as slave. The loop is held off for one settle interval during the swap. An over-voltage or over-current flag opens the output at once and latches a fault state, which only an explicit clear leaves. A state code output shows the current step.

Top module: `src_seq_ctrl`

## Requirements
- R1: While rst_ni is low, and after it is released with no start, state_o is 0 (idle) and out_rly_o, loop_en_o and adc_en_o are low.
- R2: A start_i pulse in idle steps state_o through 1 (voltage converter setup, vadc_cfg_o high), 2 (current converter setup, iadc_cfg_o high), 3 (voltage range relay init), 4 (current range relay init), 5 (output relay init) and then 6 (calibration, cal_req_o high).
- R3: Each of steps 1 to 5 and step 10 (converter enable) leaves after the first cycle in which step_done_i is high. Without the handshake it leaves after max(settle_cycles_i,1) cycles.
- R4: In step 6 the sequencer waits for cal_done_i. If cal_pass_i is low it enters state 7, which keeps the output relay open until clear_i returns it to 0.
- R5: A passing calibration leads through 8 (setpoints and mode_i latched) and 9 (range selects applied) to 10. vrange_o and irange_o are forced to 0 from steps 3 and 4 respectively until step 9 loads vrange_i and irange_i.
- R6: mode_o 0 is voltage-source operation: master_sel_o is 0 (voltage converter) and slave_sel_o is 1 (current converter). In mode 1 the roles are reversed. adc_en_o is high in states 10, 11 and 12.
- R7: In state 11 (run), loop_en_o and out_rly_o are high while no fault flag is raised.
- R8: In state 11 the sequencer moves to 12 and inverts mode_o when the slave reading is strictly above the latched limit. The slave reading is imeas_i in mode 0 and vmeas_i in mode 1. The limit is the latched iset_i in mode 0 and the latched vset_i in mode 1. An equal reading does not switch.
- R9: State 12 keeps loop_en_o low and out_rly_o high, lasts max(settle_cycles_i,1) cycles, and returns to 11.
- R10: ov_fault_i or oc_fault_i drops out_rly_o and loop_en_o in the same cycle. In any state other than 0, 7 and 13 it moves the sequencer to 13 on the next edge. State 13 holds with the relay open and the converters disabled until clear_i, which returns it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin the power-up sequence from idle |
| clear_i | input | 1 | Leave the fault or calibration-fail state |
| step_done_i | input | 1 | Completion handshake for setup and relay steps |
| settle_cycles_i | input | SETTLE_W | Settle interval in cycles |
| cal_done_i | input | 1 | Calibration finished |
| cal_pass_i | input | 1 | Calibration result, valid with cal_done_i |
| ov_fault_i | input | 1 | Over-voltage flag |
| oc_fault_i | input | 1 | Over-current flag |
| mode_i | input | 1 | Requested mode: 0 voltage source, 1 current source |
| vset_i | input | DATA_W | Voltage setpoint, limit in current-source mode |
| iset_i | input | DATA_W | Current setpoint, limit in voltage-source mode |
| vrange_i | input | RNG_W | Requested voltage range |
| irange_i | input | RNG_W | Requested current range |
| vmeas_i | input | DATA_W | Voltage measurement |
| imeas_i | input | DATA_W | Current measurement |
| vadc_cfg_o | output | 1 | Voltage converter setup active |
| iadc_cfg_o | output | 1 | Current converter setup active |
| cal_req_o | output | 1 | Calibration request |
| vrange_o | output | RNG_W | Voltage range relay drive |
| irange_o | output | RNG_W | Current range relay drive |
| out_rly_o | output | 1 | Output relay closed |
| adc_en_o | output | 1 | Measurement converters enabled |
| master_sel_o | output | 1 | Master converter: 0 voltage, 1 current |
| slave_sel_o | output | 1 | Slave converter: 0 voltage, 1 current |
| loop_en_o | output | 1 | Regulation loop enable |
| mode_o | output | 1 | Active mode: 0 voltage source, 1 current source |
| state_o | output | 4 | Current state code |

## Verification
The hardest situation to reach is a second crossover: a swap back from current-source to voltage-source operation. It needs a full calibrated power-up and a first swap. After that, the stimulus must move the threshold test onto the other measurement and the other latched limit. The bench drives the sequence through its handshakes and then raises the active slave reading exactly to its limit, which must not switch, and then one count above it. After the swap it lowers both readings and repeats the step against the new limit. Random setpoints, modes and settle lengths vary this path, and the faults are injected both during run and during the setup steps.

// File: rtl/src_seq_pkg.sv
package src_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE     = 4'd0,
    ST_CFG_V    = 4'd1,
    ST_CFG_I    = 4'd2,
    ST_RLY_V    = 4'd3,
    ST_RLY_I    = 4'd4,
    ST_RLY_OUT  = 4'd5,
    ST_CAL      = 4'd6,
    ST_CAL_FAIL = 4'd7,
    ST_LOAD     = 4'd8,
    ST_RANGE    = 4'd9,
    ST_ADC_ON   = 4'd10,
    ST_RUN      = 4'd11,
    ST_SWAP     = 4'd12,
    ST_FAULT    = 4'd13
  } seq_state_e;

  typedef enum logic {
    MODE_VSRC = 1'b0,
    MODE_ISRC = 1'b1
  } src_mode_e;
endpackage

// File: rtl/src_seq_timer.sv
module src_seq_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (restart_i)         cnt_q <= '0;
    else if (cnt_q != '1)       cnt_q <= cnt_q + 1'b1;
  end

  // dwell of max(limit,1) cycles counted from state entry
  assign expired_o = ({1'b0, cnt_q} + (CNT_W+1)'(1)) >= {1'b0, limit_i};
endmodule

// File: rtl/src_seq_cmp.sv
module src_seq_cmp
  import src_seq_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] vset_i,
  input  logic [DATA_W-1:0] iset_i,
  input  src_mode_e         mode_i,
  input  logic [DATA_W-1:0] vmeas_i,
  input  logic [DATA_W-1:0] imeas_i,
  output logic              over_o
);
  logic [DATA_W-1:0] vlim_q, ilim_q;
  logic [DATA_W-1:0] slave_meas, slave_lim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vlim_q <= '0;
      ilim_q <= '0;
    end else if (load_i) begin
      vlim_q <= vset_i;
      ilim_q <= iset_i;
    end
  end

  always_comb begin
    if (mode_i == MODE_VSRC) begin
      slave_meas = imeas_i;
      slave_lim  = ilim_q;
    end else begin
      slave_meas = vmeas_i;
      slave_lim  = vlim_q;
    end
  end

  assign over_o = slave_meas > slave_lim;
endmodule

// File: rtl/src_seq_fsm.sv
module src_seq_fsm
  import src_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       clear_i,
  input  logic       step_go_i,
  input  logic       expired_i,
  input  logic       cal_done_i,
  input  logic       cal_pass_i,
  input  logic       fault_i,
  input  logic       over_i,
  input  src_mode_e  mode_i,
  output seq_state_e state_q_o,
  output logic       restart_o,
  output src_mode_e  mode_q_o
);
  seq_state_e state_q, state_d;
  src_mode_e  mode_q;
  logic       fault_ok;

  assign fault_ok = !(state_q inside {ST_IDLE, ST_CAL_FAIL, ST_FAULT});

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (start_i)    state_d = ST_CFG_V;
      ST_CFG_V:    if (step_go_i)  state_d = ST_CFG_I;
      ST_CFG_I:    if (step_go_i)  state_d = ST_RLY_V;
      ST_RLY_V:    if (step_go_i)  state_d = ST_RLY_I;
      ST_RLY_I:    if (step_go_i)  state_d = ST_RLY_OUT;
      ST_RLY_OUT:  if (step_go_i)  state_d = ST_CAL;
      ST_CAL:      if (cal_done_i) state_d = cal_pass_i ? ST_LOAD : ST_CAL_FAIL;
      ST_CAL_FAIL: if (clear_i)    state_d = ST_IDLE;
      ST_LOAD:                     state_d = ST_RANGE;
      ST_RANGE:                    state_d = ST_ADC_ON;
      ST_ADC_ON:   if (step_go_i)  state_d = ST_RUN;
      ST_RUN:      if (over_i)     state_d = ST_SWAP;
      ST_SWAP:     if (expired_i)  state_d = ST_RUN;
      ST_FAULT:    if (clear_i)    state_d = ST_IDLE;
      default:                     state_d = ST_IDLE;
    endcase
    if (fault_i && fault_ok) state_d = ST_FAULT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_VSRC;
    end else begin
      state_q <= state_d;
      if (state_q == ST_LOAD)
        mode_q <= mode_i;
      else if (state_q == ST_RUN && state_d == ST_SWAP)
        mode_q <= src_mode_e'(~mode_q);
    end
  end

  assign state_q_o = state_q;
  assign restart_o = state_d != state_q;
  assign mode_q_o  = mode_q;
endmodule

// File: rtl/src_seq_ctrl.sv
module src_seq_ctrl
  import src_seq_pkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int SETTLE_W = 16,
  parameter int RNG_W    = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                clear_i,
  input  logic                step_done_i,
  input  logic [SETTLE_W-1:0] settle_cycles_i,
  input  logic                cal_done_i,
  input  logic                cal_pass_i,
  input  logic                ov_fault_i,
  input  logic                oc_fault_i,
  input  logic                mode_i,
  input  logic [DATA_W-1:0]   vset_i,
  input  logic [DATA_W-1:0]   iset_i,
  input  logic [RNG_W-1:0]    vrange_i,
  input  logic [RNG_W-1:0]    irange_i,
  input  logic [DATA_W-1:0]   vmeas_i,
  input  logic [DATA_W-1:0]   imeas_i,
  output logic                vadc_cfg_o,
  output logic                iadc_cfg_o,
  output logic                cal_req_o,
  output logic [RNG_W-1:0]    vrange_o,
  output logic [RNG_W-1:0]    irange_o,
  output logic                out_rly_o,
  output logic                adc_en_o,
  output logic                master_sel_o,
  output logic                slave_sel_o,
  output logic                loop_en_o,
  output logic                mode_o,
  output logic [3:0]          state_o
);
  localparam int N_CH = 2;

  seq_state_e state_q;
  src_mode_e  mode_q;
  logic       restart, expired, over, fault;

  assign fault = ov_fault_i | oc_fault_i;

  src_seq_timer #(.CNT_W(SETTLE_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .limit_i   (settle_cycles_i),
    .expired_o (expired)
  );

  src_seq_cmp #(.DATA_W(DATA_W)) u_cmp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (state_q == ST_LOAD),
    .vset_i  (vset_i),
    .iset_i  (iset_i),
    .mode_i  (mode_q),
    .vmeas_i (vmeas_i),
    .imeas_i (imeas_i),
    .over_o  (over)
  );

  src_seq_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .clear_i    (clear_i),
    .step_go_i  (step_done_i | expired),
    .expired_i  (expired),
    .cal_done_i (cal_done_i),
    .cal_pass_i (cal_pass_i),
    .fault_i    (fault),
    .over_i     (over),
    .mode_i     (src_mode_e'(mode_i)),
    .state_q_o  (state_q),
    .restart_o  (restart),
    .mode_q_o   (mode_q)
  );

  // range relay drives: channel 0 voltage, channel 1 current
  logic [RNG_W-1:0] rng_req [N_CH];
  logic [RNG_W-1:0] rng_q   [N_CH];
  seq_state_e       rng_init_st [N_CH];

  assign rng_req[0]     = vrange_i;
  assign rng_req[1]     = irange_i;
  assign rng_init_st[0] = ST_RLY_V;
  assign rng_init_st[1] = ST_RLY_I;

  for (genvar c = 0; c < N_CH; c++) begin : g_rng
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        rng_q[c] <= '0;
      else if (state_q == rng_init_st[c]) rng_q[c] <= '0;
      else if (state_q == ST_RANGE)       rng_q[c] <= rng_req[c];
    end
  end

  assign vrange_o = rng_q[0];
  assign irange_o = rng_q[1];

  assign vadc_cfg_o   = state_q == ST_CFG_V;
  assign iadc_cfg_o   = state_q == ST_CFG_I;
  assign cal_req_o    = state_q == ST_CAL;
  assign adc_en_o     = state_q inside {ST_ADC_ON, ST_RUN, ST_SWAP};
  assign master_sel_o = mode_q;
  assign slave_sel_o  = ~mode_q;
  assign mode_o       = mode_q;
  assign loop_en_o    = (state_q == ST_RUN) && !fault;
  assign out_rly_o    = (state_q inside {ST_RUN, ST_SWAP}) && !fault;
  assign state_o      = state_q;
endmodule

// File: rtl/src_seq_ctrl_chk.sv
module src_seq_ctrl_chk
  import src_seq_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       clear_i,
  input logic       ov_fault_i,
  input logic       oc_fault_i,
  input logic       out_rly_o,
  input logic       loop_en_o,
  input logic       mode_o,
  input logic [3:0] state_o
);
  a_r10_fault_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ov_fault_i || oc_fault_i) |-> (!out_rly_o && !loop_en_o));

  a_r10_fault_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_FAULT && !clear_i) |=> state_o == ST_FAULT);

  a_r7_relay_in_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_rly_o |-> (state_o == ST_RUN || state_o == ST_SWAP));

  a_r9_loop_off_swap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == ST_SWAP |-> !loop_en_o);

  a_r8_swap_flips_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_SWAP && $past(state_o) == ST_RUN) |-> mode_o != $past(mode_o));

  a_r4_cal_fail_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_CAL_FAIL && !clear_i) |=> (state_o == ST_CAL_FAIL && !out_rly_o));

  a_r2_cfg_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == ST_CFG_V |=> (state_o == ST_CFG_V || state_o == ST_CFG_I || state_o == ST_FAULT));
endmodule

bind src_seq_ctrl src_seq_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clear_i    (clear_i),
  .ov_fault_i (ov_fault_i),
  .oc_fault_i (oc_fault_i),
  .out_rly_o  (out_rly_o),
  .loop_en_o  (loop_en_o),
  .mode_o     (mode_o),
  .state_o    (state_o)
);

// File: tb/src_seq_ctrl_tb.sv
`timescale 1ns/1ps
module src_seq_ctrl_tb;
  localparam int DATA_W   = 24;
  localparam int SETTLE_W = 16;
  localparam int RNG_W    = 2;

  logic                clk_i = 1'b0;
  logic                rst_ni = 1'b0;
  logic                start_i = 0, clear_i = 0, step_done_i = 0;
  logic [SETTLE_W-1:0] settle_cycles_i = '0;
  logic                cal_done_i = 0, cal_pass_i = 0;
  logic                ov_fault_i = 0, oc_fault_i = 0, mode_i = 0;
  logic [DATA_W-1:0]   vset_i = '0, iset_i = '0, vmeas_i = '0, imeas_i = '0;
  logic [RNG_W-1:0]    vrange_i = '0, irange_i = '0;
  logic                vadc_cfg_o, iadc_cfg_o, cal_req_o, out_rly_o, adc_en_o;
  logic                master_sel_o, slave_sel_o, loop_en_o, mode_o;
  logic [RNG_W-1:0]    vrange_o, irange_o;
  logic [3:0]          state_o;

  src_seq_ctrl #(.DATA_W(DATA_W), .SETTLE_W(SETTLE_W), .RNG_W(RNG_W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .clear_i(clear_i),
    .step_done_i(step_done_i), .settle_cycles_i(settle_cycles_i),
    .cal_done_i(cal_done_i), .cal_pass_i(cal_pass_i),
    .ov_fault_i(ov_fault_i), .oc_fault_i(oc_fault_i), .mode_i(mode_i),
    .vset_i(vset_i), .iset_i(iset_i), .vrange_i(vrange_i), .irange_i(irange_i),
    .vmeas_i(vmeas_i), .imeas_i(imeas_i),
    .vadc_cfg_o(vadc_cfg_o), .iadc_cfg_o(iadc_cfg_o), .cal_req_o(cal_req_o),
    .vrange_o(vrange_o), .irange_o(irange_o), .out_rly_o(out_rly_o),
    .adc_en_o(adc_en_o), .master_sel_o(master_sel_o), .slave_sel_o(slave_sel_o),
    .loop_en_o(loop_en_o), .mode_o(mode_o), .state_o(state_o)
  );

  always #2.5 clk_i = ~clk_i;

  int vec_cnt = 0;
  int err_cnt = 0;
  bit done_flag = 0;

  task automatic chk(input string req, input longint act, input longint exp);
    vec_cnt++;
    if (act != exp) begin
      err_cnt++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  function automatic int eff(input int s);
    return (s < 1) ? 1 : s;
  endfunction

  task automatic dwell(input int code, input int exp_n, input string req);
    int n = 0;
    while (int'(state_o) == code && n < 2000) begin
      n++;
      tick();
    end
    chk(req, n, exp_n);
  endtask

  // start to calibration step; returns at first cycle of state 6
  task automatic power_up(input int settle, input logic use_done);
    int d;
    d = use_done ? 1 : eff(settle);
    settle_cycles_i = SETTLE_W'(settle);
    step_done_i = use_done;
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
    chk("R2 first step code", state_o, 1);
    chk("R2 vadc_cfg in step 1", vadc_cfg_o, 1);
    dwell(1, d, "R3 dwell step 1");
    chk("R2 iadc_cfg in step 2", iadc_cfg_o, 1);
    dwell(2, d, "R3 dwell step 2");
    dwell(3, d, "R3 dwell step 3");
    chk("R5 vrange forced 0 after step 3", vrange_o, 0);
    dwell(4, d, "R3 dwell step 4");
    chk("R5 irange forced 0 after step 4", irange_o, 0);
    dwell(5, d, "R3 dwell step 5");
    chk("R2 calibration code", state_o, 6);
    chk("R4 cal_req in step 6", cal_req_o, 1);
    step_done_i = 1'b0;
  endtask

  // passing calibration through to run
  task automatic cal_to_run(input int settle, input logic use_done);
    cal_pass_i = 1'b1;
    cal_done_i = 1'b1;
    tick();
    cal_done_i = 1'b0;
    cal_pass_i = 1'b0;
    chk("R5 load code", state_o, 8);
    tick();
    chk("R5 range code", state_o, 9);
    tick();
    chk("R5 converter enable code", state_o, 10);
    chk("R6 adc_en in step 10", adc_en_o, 1);
    chk("R5 vrange applied", vrange_o, vrange_i);
    chk("R5 irange applied", irange_o, irange_i);
    chk("R6 mode latched", mode_o, mode_i);
    chk("R6 master role", master_sel_o, mode_i);
    chk("R6 slave role", slave_sel_o, !mode_i);
    step_done_i = use_done;
    dwell(10, use_done ? 1 : eff(settle), "R3 dwell step 10");
    step_done_i = 1'b0;
    chk("R7 run code", state_o, 11);
    chk("R7 loop_en in run", loop_en_o, 1);
    chk("R7 relay in run", out_rly_o, 1);
  endtask

  // equal then over-limit reading on the active slave; returns in run
  task automatic crossover(input int settle);
    logic m;
    m = mode_o;
    vmeas_i = '0;
    imeas_i = '0;
    if (m == 1'b0) imeas_i = iset_i; else vmeas_i = vset_i;
    repeat (3) tick();
    chk("R8 equal reading keeps run", state_o, 11);
    chk("R8 equal reading keeps mode", mode_o, m);
    if (m == 1'b0) imeas_i = iset_i + 1'b1; else vmeas_i = vset_i + 1'b1;
    tick();
    chk("R8 over limit enters swap", state_o, 12);
    chk("R8 mode inverted", mode_o, !m);
    chk("R6 master swapped", master_sel_o, !m);
    chk("R6 slave swapped", slave_sel_o, m);
    chk("R9 loop off in swap", loop_en_o, 0);
    chk("R9 relay held in swap", out_rly_o, 1);
    vmeas_i = '0;
    imeas_i = '0;
    dwell(12, eff(settle), "R9 swap dwell");
    chk("R9 back to run", state_o, 11);
    chk("R9 loop back on", loop_en_o, 1);
  endtask

  task automatic fault_and_clear(input logic use_ov);
    if (use_ov) ov_fault_i = 1'b1; else oc_fault_i = 1'b1;
    #1;
    chk("R10 relay opens same cycle", out_rly_o, 0);
    chk("R10 loop off same cycle", loop_en_o, 0);
    tick();
    chk("R10 fault code", state_o, 13);
    ov_fault_i = 1'b0;
    oc_fault_i = 1'b0;
    start_i = 1'b1;
    repeat (3) tick();
    start_i = 1'b0;
    chk("R10 fault latched", state_o, 13);
    chk("R10 relay open in fault", out_rly_o, 0);
    chk("R10 converters off in fault", adc_en_o, 0);
    clear_i = 1'b1;
    tick();
    clear_i = 1'b0;
    chk("R10 clear to idle", state_o, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    if (!done_flag) begin
      err_cnt++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
      $finish;
    end
  end

  initial begin : stim
    int unsigned seed;
    seed = 32'd5150;
    void'($urandom(seed));

    repeat (3) tick();
    chk("R1 idle in reset", state_o, 0);
    chk("R1 relay open in reset", out_rly_o, 0);
    chk("R1 loop off in reset", loop_en_o, 0);
    chk("R1 converters off in reset", adc_en_o, 0);
    rst_ni = 1'b1;
    repeat (2) tick();
    chk("R1 idle after reset", state_o, 0);

    // calibration fail
    power_up(3, 1'b0);
    cal_pass_i = 1'b0;
    cal_done_i = 1'b1;
    tick();
    cal_done_i = 1'b0;
    chk("R4 fail code", state_o, 7);
    start_i = 1'b1;
    repeat (4) tick();
    start_i = 1'b0;
    chk("R4 fail held", state_o, 7);
    chk("R4 relay open on fail", out_rly_o, 0);
    clear_i = 1'b1;
    tick();
    clear_i = 1'b0;
    chk("R4 clear to idle", state_o, 0);

    // handshake-driven run, double crossover, long settle
    vset_i = 24'd5000; iset_i = 24'd1200; mode_i = 1'b0;
    vrange_i = 2'd2; irange_i = 2'd1;
    power_up(40, 1'b1);
    cal_to_run(40, 1'b1);
    crossover(40);
    crossover(40);
    fault_and_clear(1'b1);

    // fault during setup
    settle_cycles_i = SETTLE_W'(5);
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
    tick();
    chk("R10 setup step active", state_o, 1);
    oc_fault_i = 1'b1;
    tick();
    oc_fault_i = 1'b0;
    chk("R10 fault from setup", state_o, 13);
    clear_i = 1'b1;
    tick();
    clear_i = 1'b0;
    chk("R10 clear from setup fault", state_o, 0);

    // random trials
    for (int t = 0; t < 24; t++) begin
      int s;
      s = int'($urandom % 6);
      vset_i   = DATA_W'($urandom) & 24'h7FFFFF;
      iset_i   = DATA_W'($urandom) & 24'h7FFFFF;
      mode_i   = 1'($urandom);
      vrange_i = RNG_W'($urandom);
      irange_i = RNG_W'($urandom);
      power_up(s, 1'($urandom % 4 == 0));
      cal_to_run(s, 1'b0);
      crossover(s);
      if ($urandom % 2 == 0) crossover(s);
      fault_and_clear(1'($urandom));
    end

    done_flag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end
endmodule